// File: doc/BRIEF.md
# SPI Flash Access Guard

The guard sits beside a single-lane SPI link between a host and its flash devices and listens to every frame at the same moment the flash does. It decodes the opening command byte and, for operations that carry one, the 24-bit address that follows. The result is compared against a small table of address windows, each with its own read, program and erase permissions. As long as traffic is legal the guard only watches: the flash chip select it hands on is the host's chip select, and every response output stays idle.

When a frame breaks the rules, the guard responds in one of two ways. A full lockdown forces the flash chip select inactive. It then disconnects the host bus segment, pulses the flash reset and raises the host reset/alert line. The block then stays frozen until firmware clears it. A lockdown can be told to wait for a go signal from a chip-level coordinator before the disruptive steps. For reads, a lighter response can be selected instead. This response cuts the flash chip select before the data phase, logs the event, and re-arms on its own for the next frame. A status register records the first offending command, its address and the response taken.

The SPI inputs are oversampled by the system clock. Each SCLK high and low phase must last at least 6 system clock cycles, and chip select must stay high for at least 4 cycles between frames.

Top module: `spi_guard`

## Requirements
- R1: With no response in progress, `flash_cs_n` equals `spi_cs_n`, and `iso_en`, `flash_rst`, `host_alert` and `irq` are low. After reset the status register reads 0.
- R2: Frames are SPI mode 0, MSB first. The first 8 bits are the command. Commands 03h and 0Bh are reads, 02h is a program, and 20h and D8h are erases; each of these is followed by a 24-bit address. C7h is a chip erase and carries no address. Any other value is an unknown command.
- R3: The region table has 4 entries. Entry i has its start address at register 4+2i, bits [23:0], and its end address at register 5+2i, bits [23:0]. The same end register holds the read, program and erase permissions in bits 28, 29 and 30. An access is legal only if its address lies inside an entry, with both bounds inclusive, whose permission for that operation is set. A chip erase is legal only if one entry with erase permission spans 000000h to FFFFFFh.
- R4: The control register is at address 0, with bit0 enable, bit1 strict, bit2 light-read and bit3 wait-for-go. An unknown command is a violation only when strict is set, and is ignored otherwise.
- R5: With enable clear, no frame causes a violation.
- R6: A full lockdown forces `flash_cs_n` high, then raises `iso_en` one cycle later. It then drives `flash_rst` high for exactly RST_CYC cycles (default 8) while `iso_en` stays high, and after that raises `host_alert`.
- R7: After a lockdown completes, `flash_cs_n` stays high and `iso_en` and `host_alert` stay asserted until firmware writes 1 to bit0 of register 2. That write releases the lockdown and clears the status.
- R8: With wait-for-go set, a lockdown forces `flash_cs_n` high at once but holds `iso_en`, `flash_rst` and `host_alert` low until `chain_go` is seen high.
- R9: With light-read set, an illegal read drives `flash_cs_n` high before the first data bit and keeps it high until the host raises `spi_cs_n`. It sets `irq` but does not assert `iso_en`, `flash_rst` or `host_alert`. With light-read clear, an illegal read causes a full lockdown.
- R10: After a light-read response, the next frame is checked with no firmware action. A legal frame passes through, and another illegal read is cut again.
- R11: Register 2 reads pending (bit0), lockdown held (bit1), response kind (bits [3:2]: 1 light read, 2 full) and command (bits [15:8]). Register 3 reads the address, which is 0 for frames that carry no address. These fields are captured at the first violation and kept unchanged by later ones until cleared, and `irq` equals the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Host SPI clock |
| spi_cs_n | input | 1 | Host flash chip select, active low |
| spi_mosi | input | 1 | Host serial data toward flash |
| chain_go | input | 1 | Coordinator permission to finish a held lockdown |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| flash_cs_n | output | 1 | Chip select passed to flash |
| iso_en | output | 1 | Host bus segment isolation enable |
| flash_rst | output | 1 | Flash reset pulse |
| host_alert | output | 1 | Host reset / stop request |
| irq | output | 1 | Violation interrupt |

## Verification
The hardest condition to reach from the ports is the light read cut. It happens inside a live frame, in the short gap between the rising SCLK edge of the last address bit and the falling edge on which the flash would start to drive data. The bench holds chip select low after shifting the address, samples `flash_cs_n` while the host still has `spi_cs_n` low, and then sends a second illegal read without any firmware write. This shows that the response re-arms and that the captured address is kept. The lockdown order is checked by a monitor that counts `flash_rst` cycles and flags any of them without isolation. The monitor runs while `chain_go` is held back and again after it is released.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

    localparam int SG_ADDR_W = 24;
    localparam int SG_CMD_W  = 8;
    localparam int SG_DATA_W = 32;

    // register map
    localparam int REG_CTRL     = 0;
    localparam int REG_STAT     = 2;
    localparam int REG_SADDR    = 3;
    localparam int REG_RGN_BASE = 4;
    localparam int PERM_RD_BIT  = 28;
    localparam int PERM_WR_BIT  = 29;
    localparam int PERM_ER_BIT  = 30;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_PROG, OP_ERASE, OP_CHIP, OP_OTHER
    } op_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0, ACT_LIGHT = 2'd1, ACT_FULL = 2'd2
    } act_e;

    typedef struct packed {
        logic                 valid;
        op_e                  op;
        logic [SG_CMD_W-1:0]  cmd;
        logic [SG_ADDR_W-1:0] lo;
        logic [SG_ADDR_W-1:0] hi;
    } chk_req_t;

    typedef struct packed {
        logic wait_go;
        logic light;
        logic strict;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [SG_ADDR_W-1:0] lo;
        logic [SG_ADDR_W-1:0] hi;
        logic                 rd;
        logic                 wr;
        logic                 er;
    } region_t;

    function automatic op_e classify(input logic [SG_CMD_W-1:0] c);
        case (c)
            8'h03, 8'h0B: return OP_READ;
            8'h02:        return OP_PROG;
            8'h20, 8'hD8: return OP_ERASE;
            8'hC7:        return OP_CHIP;
            default:      return OP_OTHER;
        endcase
    endfunction

    function automatic logic carries_addr(input op_e o);
        return (o == OP_READ) || (o == OP_PROG) || (o == OP_ERASE);
    endfunction

endpackage

// File: rtl/sg_frame_decoder.sv
module sg_frame_decoder
    import spi_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output chk_req_t req,
    output logic     frame_end
);
    localparam int FRAME_BITS = SG_CMD_W + SG_ADDR_W;
    localparam int BW         = $clog2(FRAME_BITS + 1);

    logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
    logic                   sclk_q, cs_q;
    logic                   sclk_s, cs_s, mosi_s, rise;
    logic [BW-1:0]          bitcnt;
    logic [SG_ADDR_W-1:0]   shreg;
    logic [SG_CMD_W-1:0]    cmd_q;
    op_e                    op_q;
    logic [SG_CMD_W-1:0]    nxt_cmd;
    logic [SG_ADDR_W-1:0]   nxt_addr;

    assign sclk_s   = sclk_sync[SYNC_STAGES-1];
    assign cs_s     = cs_sync[SYNC_STAGES-1];
    assign mosi_s   = mosi_sync[SYNC_STAGES-1];
    assign rise     = sclk_s & ~sclk_q;
    assign nxt_cmd  = {shreg[SG_CMD_W-2:0], mosi_s};
    assign nxt_addr = {shreg[SG_ADDR_W-2:0], mosi_s};
    assign frame_end = cs_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
            sclk_q    <= sclk_s;
            cs_q      <= cs_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt <= '0;
            shreg  <= '0;
            cmd_q  <= '0;
            op_q   <= OP_NONE;
            req    <= '0;
        end else begin
            req.valid <= 1'b0;
            if (cs_s) begin
                bitcnt <= '0;
                op_q   <= OP_NONE;
            end else if (rise && (bitcnt < BW'(FRAME_BITS))) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= nxt_addr;
                if (bitcnt == BW'(SG_CMD_W - 1)) begin
                    cmd_q <= nxt_cmd;
                    op_q  <= classify(nxt_cmd);
                    if (!carries_addr(classify(nxt_cmd))) begin
                        req.valid <= 1'b1;
                        req.op    <= classify(nxt_cmd);
                        req.cmd   <= nxt_cmd;
                        req.lo    <= '0;
                        req.hi    <= '1;
                    end
                end
                if ((bitcnt == BW'(FRAME_BITS - 1)) && carries_addr(op_q)) begin
                    req.valid <= 1'b1;
                    req.op    <= op_q;
                    req.cmd   <= cmd_q;
                    req.lo    <= nxt_addr;
                    req.hi    <= nxt_addr;
                end
            end
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= BW'(FRAME_BITS));
    p_frame_restart_r2: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> (bitcnt == '0));

endmodule

// File: rtl/sg_rule_check.sv
module sg_rule_check
    import spi_guard_pkg::*;
#(
    parameter int N_REGION = 4
) (
    input  chk_req_t                req,
    input  ctrl_t                   ctrl,
    input  region_t [N_REGION-1:0]  rgn,
    output logic                    viol,
    output logic                    is_read
);
    logic [N_REGION-1:0] hit;

    for (genvar i = 0; i < N_REGION; i++) begin : g_rgn
        logic allow;
        always_comb begin
            case (req.op)
                OP_READ:            allow = rgn[i].rd;
                OP_PROG:            allow = rgn[i].wr;
                OP_ERASE, OP_CHIP:  allow = rgn[i].er;
                default:            allow = 1'b0;
            endcase
            hit[i] = allow && (req.lo >= rgn[i].lo) && (req.hi <= rgn[i].hi);
        end
    end

    always_comb begin
        is_read = (req.op == OP_READ);
        if (!req.valid || !ctrl.en)
            viol = 1'b0;
        else if (req.op == OP_OTHER)
            viol = ctrl.strict;
        else
            viol = ~|hit;
    end

endmodule

// File: rtl/sg_intervene.sv
module sg_intervene
    import spi_guard_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic viol,
    input  logic is_read,
    input  logic light_en,
    input  logic wait_go,
    input  logic chain_go,
    input  logic frame_end,
    input  logic clr_req,
    output logic cs_block,
    output logic iso_en,
    output logic flash_rst,
    output logic host_alert,
    output logic busy,
    output logic take,
    output act_e take_kind
);
    localparam int CW = $clog2(RST_CYC + 1);

    typedef enum logic [2:0] {S_ARMED, S_FORCE, S_ISO, S_RESET, S_HELD} st_e;

    st_e           state;
    logic          cut;
    logic [CW-1:0] cnt;

    assign take      = viol && (state == S_ARMED) && !cut;
    assign take_kind = (light_en && is_read) ? ACT_LIGHT : ACT_FULL;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_ARMED;
            cut   <= 1'b0;
            cnt   <= '0;
        end else begin
            if (frame_end) cut <= 1'b0;
            case (state)
                S_ARMED: if (take) begin
                    if (take_kind == ACT_LIGHT) cut <= 1'b1;
                    else                        state <= S_FORCE;
                end
                S_FORCE: if (!wait_go || chain_go) state <= S_ISO;
                S_ISO: begin
                    state <= S_RESET;
                    cnt   <= '0;
                end
                S_RESET: begin
                    if (cnt == CW'(RST_CYC - 1)) state <= S_HELD;
                    else                         cnt   <= cnt + 1'b1;
                end
                S_HELD: if (clr_req) state <= S_ARMED;
                default: state <= S_ARMED;
            endcase
        end
    end

    assign cs_block   = cut || (state != S_ARMED);
    assign iso_en     = (state == S_ISO) || (state == S_RESET) || (state == S_HELD);
    assign flash_rst  = (state == S_RESET);
    assign host_alert = (state == S_HELD);
    assign busy       = (state == S_FORCE) || (state == S_ISO) || (state == S_RESET);

    p_iso_after_force_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(iso_en) |-> $past(cs_block));
    p_reset_needs_iso_r6: assert property (@(posedge clk) disable iff (rst)
        flash_rst |-> iso_en);
    p_alert_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(host_alert) |-> $past(flash_rst));
    p_hold_for_go_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_FORCE && wait_go && !chain_go) |=> !iso_en);
    p_cut_is_light_r9: assert property (@(posedge clk) disable iff (rst)
        cut |-> !iso_en && !host_alert);

endmodule

// File: rtl/spi_guard.sv
module spi_guard
    import spi_guard_pkg::*;
#(
    parameter int N_REGION    = 4,
    parameter int RST_CYC     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REG_AW      = $clog2(REG_RGN_BASE + 2 * N_REGION)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    input  logic                 chain_go,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [SG_DATA_W-1:0] reg_wdata,
    output logic [SG_DATA_W-1:0] reg_rdata,
    output logic                 flash_cs_n,
    output logic                 iso_en,
    output logic                 flash_rst,
    output logic                 host_alert,
    output logic                 irq
);
    chk_req_t               req;
    logic                   frame_end;
    ctrl_t                  ctrl;
    region_t [N_REGION-1:0] rgn;
    logic                   viol, is_read;
    logic                   cs_block, busy, take;
    act_e                   take_kind;
    logic                   clr_req;

    logic                   pend;
    act_e                   cap_kind;
    logic [SG_CMD_W-1:0]    cap_cmd;
    logic [SG_ADDR_W-1:0]   cap_addr;

    sg_frame_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .req(req), .frame_end(frame_end)
    );

    sg_rule_check #(.N_REGION(N_REGION)) u_chk (
        .req(req), .ctrl(ctrl), .rgn(rgn), .viol(viol), .is_read(is_read)
    );

    sg_intervene #(.RST_CYC(RST_CYC)) u_act (
        .clk(clk), .rst(rst), .viol(viol), .is_read(is_read),
        .light_en(ctrl.light), .wait_go(ctrl.wait_go), .chain_go(chain_go),
        .frame_end(frame_end), .clr_req(clr_req),
        .cs_block(cs_block), .iso_en(iso_en), .flash_rst(flash_rst),
        .host_alert(host_alert), .busy(busy), .take(take), .take_kind(take_kind)
    );

    assign clr_req    = reg_we && (reg_addr == REG_AW'(REG_STAT)) && reg_wdata[0] && !busy;
    assign flash_cs_n = spi_cs_n | cs_block;
    assign irq        = pend;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (reg_we && reg_addr == REG_AW'(REG_CTRL))
            ctrl <= ctrl_t'(reg_wdata[3:0]);
    end

    for (genvar i = 0; i < N_REGION; i++) begin : g_rgn_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                rgn[i].lo <= '1;
                rgn[i].hi <= '0;
                rgn[i].rd <= 1'b0;
                rgn[i].wr <= 1'b0;
                rgn[i].er <= 1'b0;
            end else if (reg_we) begin
                if (reg_addr == REG_AW'(REG_RGN_BASE + 2 * i))
                    rgn[i].lo <= reg_wdata[SG_ADDR_W-1:0];
                if (reg_addr == REG_AW'(REG_RGN_BASE + 2 * i + 1)) begin
                    rgn[i].hi <= reg_wdata[SG_ADDR_W-1:0];
                    rgn[i].rd <= reg_wdata[PERM_RD_BIT];
                    rgn[i].wr <= reg_wdata[PERM_WR_BIT];
                    rgn[i].er <= reg_wdata[PERM_ER_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            cap_kind <= ACT_NONE;
            cap_cmd  <= '0;
            cap_addr <= '0;
        end else begin
            if (clr_req) begin
                pend     <= 1'b0;
                cap_kind <= ACT_NONE;
                cap_cmd  <= '0;
                cap_addr <= '0;
            end
            if (take && !pend) begin
                pend     <= 1'b1;
                cap_kind <= take_kind;
                cap_cmd  <= req.cmd;
                cap_addr <= carries_addr(req.op) ? req.lo : '0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(REG_CTRL)) begin
            reg_rdata[3:0] = ctrl;
        end else if (reg_addr == REG_AW'(REG_STAT)) begin
            reg_rdata[0]    = pend;
            reg_rdata[1]    = host_alert;
            reg_rdata[3:2]  = cap_kind;
            reg_rdata[15:8] = cap_cmd;
        end else if (reg_addr == REG_AW'(REG_SADDR)) begin
            reg_rdata[SG_ADDR_W-1:0] = cap_addr;
        end else begin
            for (int i = 0; i < N_REGION; i++) begin
                if (reg_addr == REG_AW'(REG_RGN_BASE + 2 * i))
                    reg_rdata[SG_ADDR_W-1:0] = rgn[i].lo;
                if (reg_addr == REG_AW'(REG_RGN_BASE + 2 * i + 1)) begin
                    reg_rdata[SG_ADDR_W-1:0] = rgn[i].hi;
                    reg_rdata[PERM_RD_BIT]   = rgn[i].rd;
                    reg_rdata[PERM_WR_BIT]   = rgn[i].wr;
                    reg_rdata[PERM_ER_BIT]   = rgn[i].er;
                end
            end
        end
    end

    p_alert_has_irq_r7: assert property (@(posedge clk) disable iff (rst)
        host_alert |-> irq);
    p_status_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr_req) |=> pend && $stable(cap_cmd) && $stable(cap_addr));
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !cs_block |-> !iso_en && !host_alert);

endmodule

// File: tb/tb_spi_guard.sv
module tb_spi_guard;
    import spi_guard_pkg::*;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, chain_go = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flash_cs_n, iso_en, flash_rst, host_alert, irq;

    int checks = 0, fails = 0;
    int rst_cnt = 0, rst_no_iso = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_guard dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .chain_go(chain_go), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flash_cs_n(flash_cs_n), .iso_en(iso_en), .flash_rst(flash_rst),
        .host_alert(host_alert), .irq(irq)
    );

    always @(negedge clk) begin
        if (flash_rst) begin
            rst_cnt++;
            if (!iso_en) rst_no_iso++;
        end
    end

    typedef struct packed {
        logic [7:0]  cmd;
        logic [23:0] addr;
        logic        has_addr;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h03, 24'h000100, 1'b1, 2'd0},
        '{8'h0B, 24'h0FFFFF, 1'b1, 2'd0},
        '{8'h03, 24'h300000, 1'b1, 2'd1},
        '{8'h02, 24'h000200, 1'b1, 2'd2},
        '{8'h02, 24'h1FFFFF, 1'b1, 2'd0},
        '{8'h20, 24'h100000, 1'b1, 2'd0},
        '{8'hD8, 24'h200000, 1'b1, 2'd2},
        '{8'hC7, 24'h000000, 1'b0, 2'd2},
        '{8'h9F, 24'h000000, 1'b0, 2'd2},
        '{8'h02, 24'h200000, 1'b1, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic spi_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            spi_mosi = v[i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    // leaves chip select low after the last bit
    task automatic frame_open(input logic [7:0] c, input logic [23:0] a, input bit has_a);
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        spi_bits({24'h0, c}, 8);
        if (has_a) spi_bits({8'h0, a}, 24);
        wait_clk(1);
    endtask

    task automatic frame_close();
        @(negedge clk);
        spi_cs_n = 1'b1;
        wait_clk(30);
    endtask

    task automatic clear_status();
        wr(4'd2, 32'h1);
        wait_clk(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        rd(4'd2, d);
        chk(d == 0, "R1 status after reset", d, 0);
        chk({flash_cs_n, iso_en, flash_rst, host_alert, irq} == 5'b10000, "R1 outputs idle",
            {flash_cs_n, iso_en, flash_rst, host_alert, irq}, 5'b10000);

        // R3 regions: 0 read only, 1 all, 2 read+program, 3 unused
        wr(4'd4, 32'h000000); wr(4'd5, 32'h1000_0000 | 32'h0FFFFF);
        wr(4'd6, 32'h100000); wr(4'd7, 32'h7000_0000 | 32'h1FFFFF);
        wr(4'd8, 32'h200000); wr(4'd9, 32'h3000_0000 | 32'h2FFFFF);
        wr(4'd0, 32'h7);

        for (int v = 0; v < NV; v++) begin
            frame_open(VECS[v].cmd, VECS[v].addr, VECS[v].has_addr);
            // R9 / R6 / R1: chip select as seen by flash during the frame
            chk(flash_cs_n == (VECS[v].kind != 0), "R2 R3 R9 flash_cs_n in frame",
                flash_cs_n, VECS[v].kind != 0);
            frame_close();
            chk(irq == (VECS[v].kind != 0), "R3 R4 irq", irq, VECS[v].kind != 0);
            chk(iso_en == (VECS[v].kind == 2), "R6 R9 isolation", iso_en, VECS[v].kind == 2);
            rd(4'd2, d);
            chk(d[3:2] == VECS[v].kind, "R11 kind", d[3:2], VECS[v].kind);
            if (VECS[v].kind != 0) begin
                chk(d[15:8] == VECS[v].cmd, "R11 command", d[15:8], VECS[v].cmd);
                rd(4'd3, d);
                chk(d[23:0] == (VECS[v].has_addr ? VECS[v].addr : 24'h0), "R11 address",
                    d[23:0], VECS[v].addr);
                clear_status();
                chk({irq, iso_en, host_alert} == 3'b000, "R7 clear releases",
                    {irq, iso_en, host_alert}, 0);
            end
        end

        // R10 re-arm: two illegal reads with no clear, then a legal read
        frame_open(8'h03, 24'h400000, 1'b1);
        chk(flash_cs_n == 1, "R9 first cut", flash_cs_n, 1);
        frame_close();
        frame_open(8'h0B, 24'h500000, 1'b1);
        chk(flash_cs_n == 1, "R10 second cut without firmware", flash_cs_n, 1);
        frame_close();
        frame_open(8'h03, 24'h000010, 1'b1);
        chk(flash_cs_n == 0, "R10 legal frame passes", flash_cs_n, 0);
        frame_close();
        rd(4'd3, d);
        chk(d[23:0] == 24'h400000, "R11 first address kept", d[23:0], 24'h400000);
        chk(host_alert == 0 && flash_rst == 0, "R9 no lockdown", host_alert, 0);
        clear_status();

        // R4 non-strict: unknown command ignored
        wr(4'd0, 32'h5);
        frame_open(8'h9F, 24'h0, 1'b0);
        frame_close();
        chk(irq == 0, "R4 unknown ignored", irq, 0);

        // R5 disabled
        wr(4'd0, 32'h0);
        frame_open(8'h02, 24'h000000, 1'b1);
        chk(flash_cs_n == 0, "R5 disabled passes", flash_cs_n, 0);
        frame_close();
        chk(irq == 0 && iso_en == 0, "R5 disabled no irq", irq, 0);

        // R9 light-read off -> full lockdown on read
        wr(4'd0, 32'h3);
        frame_open(8'h03, 24'h300000, 1'b1);
        frame_close();
        rd(4'd2, d);
        chk(d[3:2] == 2 && host_alert, "R9 read without light mode", d[3:2], 2);
        clear_status();

        // R8 wait for go, R6 ordering
        wr(4'd0, 32'hB);
        rst_cnt = 0; rst_no_iso = 0;
        frame_open(8'h02, 24'h000000, 1'b1);
        frame_close();
        wait_clk(10);
        chk(iso_en == 0 && host_alert == 0 && rst_cnt == 0, "R8 held before go",
            {iso_en, host_alert}, 0);
        @(negedge clk); spi_cs_n = 1'b0;
        @(negedge clk);
        chk(flash_cs_n == 1, "R8 cs forced before go", flash_cs_n, 1);
        spi_cs_n = 1'b1;
        @(negedge clk); chain_go = 1'b1;
        @(negedge clk); chain_go = 1'b0;
        wait_clk(20);
        chk(rst_cnt == 8, "R6 reset pulse width", rst_cnt, 8);
        chk(rst_no_iso == 0, "R6 reset under isolation", rst_no_iso, 0);
        chk(iso_en && host_alert && !flash_rst, "R7 held state", {iso_en, host_alert, flash_rst}, 3'b110);
        @(negedge clk); spi_cs_n = 1'b0;
        @(negedge clk);
        chk(flash_cs_n == 1, "R7 cs forced in hold", flash_cs_n, 1);
        spi_cs_n = 1'b1;
        wait_clk(6);
        clear_status();
        @(negedge clk); spi_cs_n = 1'b0;
        @(negedge clk);
        chk(flash_cs_n == 0 && !iso_en && !host_alert, "R7 R1 pass-through after release",
            {flash_cs_n, iso_en, host_alert}, 0);
        spi_cs_n = 1'b1;
        wait_clk(6);

        // R3 chip erase legal with a full-span erase region
        wr(4'd0, 32'h7);
        wr(4'd10, 32'h000000); wr(4'd11, 32'h4000_0000 | 32'hFFFFFF);
        frame_open(8'hC7, 24'h0, 1'b0);
        frame_close();
        chk(irq == 0, "R3 chip erase allowed", irq, 0);

        finish_run();
    end

endmodule